// File: doc/BRIEF.md
# SDRAM Refresh and Power-Mode Sequencer

This block sits beside the main command engine of a low-power SDRAM controller and owns two duties: keeping the array refreshed and moving the memory into and out of its power-saving modes. A free-running tick counter, sized from the clock frequency, marks each distributed refresh interval (15.625 us or less). Each interval adds one refresh to an owed count. While that count is non-zero the block raises `ref_due_o`. When the main engine grants the bus, the block issues AUTO REFRESH commands back to back, spaced by the refresh cycle time, until nothing is owed.

On a level request the block enters self refresh. It issues the refresh encoding with CKE dropped in the same cycle, holds CKE low for at least the row-active time, and then returns CKE high, followed by a run of NOP cycles. A second level request drives the memory into deep power-down with its own entry encoding and brings it out again by raising CKE. Both power requests wait until the banks report idle. While the block is doing any of this, `busy_o` tells the main engine to keep off the command pins.

Top module: `sdram_pwr_seq`

## Requirements
- R1: While reset is asserted and right after it, CKE is high, the command pins carry NOP (CS#=0, RAS#=1, CAS#=1, WE#=1), and both `busy_o` and `ref_due_o` are low.
- R2: The tick counter advances once per clock while the block is not in a power-saving phase. Every REF_PERIOD = floor(CLK_KHZ*15625/1000000) clocks it adds one owed refresh. `ref_due_o` is high exactly while the owed count is non-zero.
- R3: When a refresh is owed and `ref_gnt_i` is high in the idle state, the next cycle carries the AUTO REFRESH encoding (CS#=0, RAS#=0, CAS#=0, WE#=1) with CKE high, and the owed count drops by one.
- R4: Refreshes issued back to back while the grant stays high are exactly T_RFC_CYC cycles apart, with NOP on the pins in between.
- R5: The owed count saturates at MAX_OWED. A grant held long enough then issues exactly MAX_OWED refreshes.
- R6: A self-refresh or deep power-down request is taken only in a cycle where `banks_idle_i` is high. Until then the block stays idle with CKE high.
- R7: Self-refresh entry drives the AUTO REFRESH encoding with CKE low in the same cycle. After that, CKE stays low and CS# is high (deselect) for as long as the block stays in self refresh.
- R8: CKE stays low for at least T_RAS_CYC cycles, counting the entry cycle. It stays low for as long as `sref_req_i` is held, with no upper limit.
- R9: On leaving self refresh, CKE goes high and NOP is driven for max(T_XSR_CYC, 2) cycles with `busy_o` high. Only then does the block return to idle.
- R10: Owed refreshes are dropped on entry to a power-saving mode, and the tick counter is held at zero. The first `ref_due_o` after returning to idle comes exactly REF_PERIOD cycles later.
- R11: Deep power-down entry drives CS#=0, RAS#=1, CAS#=1, WE#=0 with CKE low. CKE stays low while `dpd_req_i` is held. On release, CKE goes high with NOP for T_DPDX_CYC cycles before the block is idle again.
- R12: `busy_o` is high in every state except idle, and in particular whenever CKE is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ref_gnt_i | input | 1 | Main engine hands the command pins over for refresh |
| sref_req_i | input | 1 | Level request to stay in self refresh |
| dpd_req_i | input | 1 | Level request to stay in deep power-down |
| banks_idle_i | input | 1 | All banks are precharged |
| ref_due_o | output | 1 | At least one refresh is owed |
| busy_o | output | 1 | Block owns the command pins |
| cke_o | output | 1 | Clock enable to the memory |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |

## Verification
A cycle-by-cycle vector walk covers the power-mode paths. It holds a self-refresh request against busy banks, drops the request before the minimum low time has passed, raises a power-down request during the exit NOP run, and then enters and leaves deep power-down. Each step separates gating by `banks_idle_i`, enforcement of the minimum CKE-low time and the exact length of each NOP run. Refresh bursts after three owed intervals and after ten owed intervals tell correct spacing apart from a saturating count. A self-refresh round trip with a refresh already owed shows that the owed refresh is discarded and that the timer restarts from zero.

// File: rtl/sdram_pwr_pkg.sv
package sdram_pwr_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_AREF,
    ST_RFC_WAIT,
    ST_SREF_ENTRY,
    ST_SREF,
    ST_SREF_EXIT,
    ST_DPD_ENTRY,
    ST_DPD,
    ST_DPD_EXIT
  } pm_state_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } sdr_cmd_t;

  localparam sdr_cmd_t CMD_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam sdr_cmd_t CMD_REF = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
  localparam sdr_cmd_t CMD_DPD = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b0};
  localparam sdr_cmd_t CMD_DES = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};

  function automatic logic is_low_power(pm_state_e s);
    return (s == ST_SREF_ENTRY) || (s == ST_SREF) || (s == ST_SREF_EXIT) ||
           (s == ST_DPD_ENTRY)  || (s == ST_DPD)  || (s == ST_DPD_EXIT);
  endfunction

endpackage

// File: rtl/sdram_ref_timer.sv
module sdram_ref_timer #(
  parameter int PERIOD   = 1953,
  parameter int MAX_OWED = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic dec_i,
  output logic due_o
);
  localparam int CNT_W  = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam int OWED_W = $clog2(MAX_OWED + 1);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [OWED_W-1:0] owed_q, owed_d;
  logic              tick;

  assign tick = (cnt_q == CNT_W'(PERIOD - 1));

  always_comb begin
    if (clr_i || tick) cnt_d = '0;
    else               cnt_d = cnt_q + 1'b1;
  end

  always_comb begin
    owed_d = owed_q;
    if (clr_i)
      owed_d = '0;
    else if (tick && !dec_i && (owed_q != OWED_W'(MAX_OWED)))
      owed_d = owed_q + 1'b1;
    else if (dec_i && !tick)
      owed_d = owed_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      owed_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      owed_q <= owed_d;
    end
  end

  assign due_o = (owed_q != '0);

  AST_OWED_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    owed_q <= OWED_W'(MAX_OWED)); // R5
  AST_DEC_HAS_OWED: assert property (@(posedge clk) disable iff (!rst_n)
    dec_i |-> (owed_q != '0)); // R3
  AST_CLR_DROPS_DUE: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !due_o); // R10

endmodule

// File: rtl/sdram_wait_cnt.sv
module sdram_wait_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign cnt_en = ld_i || (cnt_q != '0);

  always_comb begin
    if (ld_i) cnt_d = ld_val_i;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sdram_cmd_enc.sv
module sdram_cmd_enc
  import sdram_pwr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  pm_state_e state_i,
  output sdr_cmd_t  cmd_o,
  output logic      cke_o,
  output logic      busy_o
);
  always_comb begin
    cmd_o = CMD_NOP;
    cke_o = 1'b1;
    unique case (state_i)
      ST_AREF:       cmd_o = CMD_REF;
      ST_SREF_ENTRY: begin cmd_o = CMD_REF; cke_o = 1'b0; end
      ST_SREF:       begin cmd_o = CMD_DES; cke_o = 1'b0; end
      ST_DPD_ENTRY:  begin cmd_o = CMD_DPD; cke_o = 1'b0; end
      ST_DPD:        begin cmd_o = CMD_DES; cke_o = 1'b0; end
      default:       ;
    endcase
  end

  assign busy_o = (state_i != ST_IDLE);

  AST_BUSY_WHEN_CKE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !cke_o |-> busy_o); // R12

endmodule

// File: rtl/sdram_pwr_seq.sv
module sdram_pwr_seq
  import sdram_pwr_pkg::*;
#(
  parameter int CLK_KHZ    = 125000,
  parameter int T_RFC_CYC  = 10,
  parameter int T_RAS_CYC  = 6,
  parameter int T_XSR_CYC  = 15,
  parameter int T_DPDX_CYC = 2,
  parameter int MAX_OWED   = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_gnt_i,
  input  logic sref_req_i,
  input  logic dpd_req_i,
  input  logic banks_idle_i,
  output logic ref_due_o,
  output logic busy_o,
  output logic cke_o,
  output logic cs_n_o,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic we_n_o
);
  localparam int REF_PERIOD = int'((64'(CLK_KHZ) * 64'd15625) / 64'd1000000);
  localparam int XSR_EFF    = (T_XSR_CYC < 2) ? 2 : T_XSR_CYC;
  localparam int WT_M1      = (T_RFC_CYC > T_RAS_CYC) ? T_RFC_CYC : T_RAS_CYC;
  localparam int WT_M2      = (XSR_EFF > T_DPDX_CYC) ? XSR_EFF : T_DPDX_CYC;
  localparam int WT_MAX     = (WT_M1 > WT_M2) ? WT_M1 : WT_M2;
  localparam int WT_W       = $clog2(WT_MAX + 1);

  pm_state_e        state_q, state_d;
  logic             wt_ld, wt_zero;
  logic [WT_W-1:0]  wt_val;
  logic             ref_due;
  sdr_cmd_t         cmd;

  sdram_ref_timer #(.PERIOD(REF_PERIOD), .MAX_OWED(MAX_OWED)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (is_low_power(state_q)),
    .dec_i (state_q == ST_AREF),
    .due_o (ref_due)
  );

  sdram_wait_cnt #(.W(WT_W)) u_wait (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_i     (wt_ld),
    .ld_val_i (wt_val),
    .zero_o   (wt_zero)
  );

  sdram_cmd_enc u_enc (
    .clk     (clk),
    .rst_n   (rst_n),
    .state_i (state_q),
    .cmd_o   (cmd),
    .cke_o   (cke_o),
    .busy_o  (busy_o)
  );

  always_comb begin
    state_d = state_q;
    wt_ld   = 1'b0;
    wt_val  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (ref_due && ref_gnt_i) begin
          state_d = ST_AREF;
          wt_ld   = 1'b1;
          wt_val  = WT_W'(T_RFC_CYC - 1);
        end else if (sref_req_i && banks_idle_i) begin
          state_d = ST_SREF_ENTRY;
          wt_ld   = 1'b1;
          wt_val  = WT_W'(T_RAS_CYC - 1);
        end else if (dpd_req_i && banks_idle_i) begin
          state_d = ST_DPD_ENTRY;
        end
      end
      ST_AREF:     state_d = ST_RFC_WAIT;
      ST_RFC_WAIT: begin
        if (wt_zero) begin
          if (ref_due && ref_gnt_i) begin
            state_d = ST_AREF;
            wt_ld   = 1'b1;
            wt_val  = WT_W'(T_RFC_CYC - 1);
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      ST_SREF_ENTRY: state_d = ST_SREF;
      ST_SREF: begin
        if (wt_zero && !sref_req_i) begin
          state_d = ST_SREF_EXIT;
          wt_ld   = 1'b1;
          wt_val  = WT_W'(XSR_EFF - 1);
        end
      end
      ST_SREF_EXIT: if (wt_zero) state_d = ST_IDLE;
      ST_DPD_ENTRY: state_d = ST_DPD;
      ST_DPD: begin
        if (!dpd_req_i) begin
          state_d = ST_DPD_EXIT;
          wt_ld   = 1'b1;
          wt_val  = WT_W'(T_DPDX_CYC - 1);
        end
      end
      ST_DPD_EXIT: if (wt_zero) state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign ref_due_o = ref_due;
  assign cs_n_o    = cmd.cs_n;
  assign ras_n_o   = cmd.ras_n;
  assign cas_n_o   = cmd.cas_n;
  assign we_n_o    = cmd.we_n;

  AST_CKE_FALL_ENCODING: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke_o) |-> (!cs_n_o && ((!ras_n_o && !cas_n_o && we_n_o) ||
                                  (ras_n_o && cas_n_o && !we_n_o)))); // R7
  AST_ENTRY_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke_o) |-> $past(banks_idle_i)); // R6
  AST_SREF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SREF && sref_req_i) |=> !cke_o); // R8
  AST_DPD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DPD && dpd_req_i) |=> !cke_o); // R11
  AST_REF_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_AREF) |-> ($past(ref_gnt_i) && $past(ref_due))); // R3

endmodule

// File: tb/sdram_pwr_seq_tb.sv
module sdram_pwr_seq_tb;
  localparam int CLK_KHZ = 2048;
  localparam int PER     = 32;
  localparam int TRFC    = 4;
  localparam int TRAS    = 5;
  localparam int TXSR    = 6;
  localparam int TDPDX   = 3;
  localparam int MOWED   = 8;

  logic clk, rst_n, gnt, sref, dpd, idle;
  logic due, busy, cke, cs_n, ras_n, cas_n, we_n;
  int nvec = 0, nmis = 0;

  sdram_pwr_seq #(.CLK_KHZ(CLK_KHZ), .T_RFC_CYC(TRFC), .T_RAS_CYC(TRAS),
                  .T_XSR_CYC(TXSR), .T_DPDX_CYC(TDPDX), .MAX_OWED(MOWED)) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_gnt_i(gnt), .sref_req_i(sref), .dpd_req_i(dpd),
    .banks_idle_i(idle), .ref_due_o(due), .busy_o(busy), .cke_o(cke),
    .cs_n_o(cs_n), .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {sref,dpd,gnt,idle} then expected {cke, cs/ras/cas/we, busy, due}
  localparam logic [10:0] VEC [0:21] = '{
    11'b1000_1_0111_0_0, 11'b1000_1_0111_0_0, 11'b1001_0_0001_1_0,
    11'b0001_0_1111_1_0, 11'b0001_0_1111_1_0, 11'b0001_0_1111_1_0,
    11'b0001_0_1111_1_0, 11'b0001_1_0111_1_0, 11'b0101_1_0111_1_0,
    11'b0101_1_0111_1_0, 11'b0101_1_0111_1_0, 11'b0101_1_0111_1_0,
    11'b0101_1_0111_1_0, 11'b0100_1_0111_0_0, 11'b0100_1_0111_0_0,
    11'b0101_0_0110_1_0, 11'b0101_0_1111_1_0, 11'b0101_0_1111_1_0,
    11'b0001_1_0111_1_0, 11'b0001_1_0111_1_0, 11'b0001_1_0111_1_0,
    11'b0001_1_0111_0_0
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nmis++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; gnt = 1'b0; sref = 1'b0; dpd = 1'b0; idle = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic logic [6:0] outs();
    return {cke, cs_n, ras_n, cas_n, we_n, busy, due};
  endfunction

  function automatic string vtag(input int i);
    if (i < 2)        return "R6 sref gated";
    else if (i == 2)  return "R7 sref entry";
    else if (i < 7)   return "R8 min low";
    else if (i < 13)  return "R9 exit nop";
    else if (i < 15)  return "R6 dpd gated";
    else              return "R11 dpd";
  endfunction

  task automatic burst(input int n, input int exp_cnt);
    int cnt = 0;
    int last = -100;
    logic gap_ok = 1'b1;
    do_reset();
    repeat (PER * n) step();
    gnt = 1'b1;
    for (int k = 1; k <= 30; k++) begin
      step();
      if ({cke, cs_n, ras_n, cas_n, we_n} == 5'b1_0001) begin
        if (cnt > 0 && (k - last) != TRFC) gap_ok = 1'b0;
        last = k;
        cnt++;
      end
    end
    gnt = 1'b0;
    chk("R5 refreshes issued", cnt, exp_cnt);
    chk("R4 refresh spacing", gap_ok, 1'b1);
    chk("R3 owed cleared after burst", due, 1'b0);
  endtask

  initial begin
    #(8 * 150000);
    nmis++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
    $finish;
  end

  initial begin
    rst_n = 1'b0; gnt = 1'b0; sref = 1'b0; dpd = 1'b0; idle = 1'b0;
    @(negedge clk);
    chk("R1 reset outputs", outs(), 7'b1_0111_0_0);
    @(negedge clk);
    rst_n = 1'b1;
    step();
    chk("R1 after reset", outs(), 7'b1_0111_0_0);

    // vector walk
    for (int i = 0; i < 22; i++) begin
      {sref, dpd, gnt, idle} = VEC[i][10:7];
      step();
      chk(vtag(i), outs(), VEC[i][6:0]);
    end

    // R2/R3/R4: single refresh
    do_reset();
    repeat (PER - 1) step();
    chk("R2 not yet due", due, 1'b0);
    step();
    chk("R2 due after period", due, 1'b1);
    gnt = 1'b1;
    step();
    gnt = 1'b0;
    chk("R3 auto refresh cmd", outs(), 7'b1_0001_1_1);
    step();
    chk("R4 nop after refresh", outs(), 7'b1_0111_1_0);
    repeat (TRFC - 2) step();
    step();
    chk("R12 idle after rfc", busy, 1'b0);

    // R4/R5 bursts
    burst(3, 3);
    burst(10, MOWED);

    // R10: owed dropped in self refresh, timer restarts
    do_reset();
    repeat (PER) step();
    chk("R2 due before sref", due, 1'b1);
    sref = 1'b1; idle = 1'b1;
    step();
    chk("R7 entry encoding", outs() & 7'b1_1111_1_0, 7'b0_0001_1_0);
    step();
    chk("R10 owed dropped", due, 1'b0);
    repeat (20) step();
    chk("R8 held while requested", outs() & 7'b1_1111_1_0, 7'b0_1111_1_0);
    sref = 1'b0;
    step();
    chk("R9 exit cke high", outs(), 7'b1_0111_1_0);
    repeat (XSR_M1()) step();
    chk("R9 still busy at last nop", busy, 1'b1);
    step();
    chk("R9 idle after nops", busy, 1'b0);
    repeat (PER - 1) step();
    chk("R10 not due early", due, 1'b0);
    step();
    chk("R10 due after restart", due, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
    $finish;
  end

  function automatic int XSR_M1();
    return TXSR - 1;
  endfunction

endmodule